// File: doc/BRIEF.md
# Input Search Selector

This block chooses which of three digital audio receivers feeds the converter. Input 0 and input 1 are the balanced ports and input 2 is the consumer port. Each receiver reports a lock flag on `valid_i`. A debounced front-panel press advances the selection. In search mode a press jumps to the next locked port and passes over dead ones. In manual mode a press moves one port along, whether or not that port is locked. The one-hot selection drives both the input multiplexer and the indicator lamps.

In search mode the selected port may have no lock. While that holds, the selector walks round the ports on its own, spending a programmable number of clock ticks on each one. The lamps therefore show the scan as it runs. The walk stops as soon as it lands on a locked port. A separate toggle pulse switches between the two modes. The block keeps no non-volatile state itself. When the mode changes, it raises a one-cycle flag so that outside logic can store the new mode. A load pulse restores a stored mode after power-up.

Top module: `input_scan_sel`

## Requirements
- R1: After reset, `sel_o` is 3'b001 (input 0), `manual_o` is 0 (search mode) and `mode_chg_o` is 0.
- R2: Exactly one bit of `sel_o` is set in every cycle. Bit i selects input i.
- R3: In manual mode (`manual_o`=1), a press moves the selection on the next clock to input (i+1) mod 3, whatever `valid_i` shows, so input 2 wraps to input 0.
- R4: In search mode, a press selects on the next clock the first input i+1, then i+2 (mod 3), whose `valid_i` bit is 1.
- R5: In search mode, a press while no input other than the current one is valid leaves the selection unchanged.
- R6: A toggle pulse without a load inverts `manual_o` on the next clock. In that same cycle `mode_chg_o` is 1 for exactly one cycle.
- R7: A load pulse sets `manual_o` to `mode_load_val_i` (1 = manual) on the next clock and takes priority over a toggle in the same cycle. A load never raises `mode_chg_o`.
- R8: In search mode, while the selected input is not valid, the selection advances by one input (mod 3) after every D clock cycles of scanning, where D is `dwell_i` and a value of 0 counts as 1.
- R9: Scanning stops once the selected input is valid. Manual mode never scans.
- R10: A press during a scan takes precedence over the scan step and restarts the dwell count.
- R11: Without a press, the selection does not change while the mode is manual or while the selected input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk |
| btn_press_i | input | 1 | One-cycle debounced select-button pulse |
| mode_tgl_i | input | 1 | One-cycle pulse that switches between search and manual mode |
| mode_load_i | input | 1 | One-cycle pulse that loads the stored mode |
| mode_load_val_i | input | 1 | Mode to load: 1 = manual, 0 = search |
| valid_i | input | 3 | Lock flag for each input, bit i for input i |
| dwell_i | input | 16 | Scan dwell time in clock cycles (0 is treated as 1) |
| sel_o | output | 3 | One-hot selected input, also drives the lamps |
| manual_o | output | 1 | Current mode: 1 = manual, 0 = search |
| mode_chg_o | output | 1 | One-cycle flag after a toggle, used to request that the mode be stored |

## Verification
The hardest situation to reach from the ports is a press that arrives partway through a scan dwell. In that case the press must win over a pending step and also restart the dwell window, so the next automatic step comes a full D cycles after the press. The stimulus drops every lock flag with a short dwell, waits two cycles, presses while nothing is valid so that the selection holds, and then counts the cycles to the next step. The sequence also uses a zero dwell, which gives a step on every cycle. It then raises a single lock flag mid-scan, so the walk has to stop on exactly that port and on no other.

// File: rtl/iss_pkg.sv
package iss_pkg;
  typedef enum logic {
    SRCH_MODE = 1'b0,
    MAN_MODE  = 1'b1
  } iss_mode_e;
endpackage

// File: rtl/iss_mode_ctl.sv
module iss_mode_ctl
  import iss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tgl_i,
  input  logic      load_i,
  input  logic      load_val_i,
  output iss_mode_e mode_o,
  output logic      chg_o
);
  iss_mode_e mode_q, mode_d;
  logic      chg_q, chg_d;

  always_comb begin
    mode_d = mode_q;
    chg_d  = 1'b0;
    if (load_i) begin
      mode_d = load_val_i ? MAN_MODE : SRCH_MODE;
    end else if (tgl_i) begin
      mode_d = (mode_q == SRCH_MODE) ? MAN_MODE : SRCH_MODE;
      chg_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SRCH_MODE;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      chg_q  <= chg_d;
    end
  end

  assign mode_o = mode_q;
  assign chg_o  = chg_q;
endmodule

// File: rtl/iss_next_pick.sv
module iss_next_pick #(
  parameter int N_IN = 3
) (
  input  logic [N_IN-1:0] sel_i,
  input  logic [N_IN-1:0] valid_i,
  output logic [N_IN-1:0] step_o,
  output logic [N_IN-1:0] hunt_o,
  output logic            found_o
);
  logic [2*N_IN-1:0] dbl;
  logic [N_IN-1:0]   cand [1:N_IN-1];
  logic [N_IN-1:1]   hit;

  assign dbl = {sel_i, sel_i};

  for (genvar k = 1; k < N_IN; k++) begin : g_rot
    assign cand[k] = dbl[N_IN-k +: N_IN];
    assign hit[k]  = |(cand[k] & valid_i);
  end

  assign step_o = cand[1];

  always_comb begin
    hunt_o  = sel_i;
    found_o = 1'b0;
    for (int k = N_IN - 1; k >= 1; k--) begin
      if (hit[k]) begin
        hunt_o  = cand[k];
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iss_dwell_tmr.sv
module iss_dwell_tmr #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [DW-1:0] dwell_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q, cnt_d, limit;
  logic          cnt_en;

  assign limit  = (dwell_i == '0) ? '0 : dwell_i - 1'b1;
  assign tick_o = run_i && !clr_i && (cnt_q >= limit);
  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    if (!run_i || clr_i || tick_o) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/input_scan_sel.sv
module input_scan_sel
  import iss_pkg::*;
#(
  parameter int N_IN = 3,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            btn_press_i,
  input  logic            mode_tgl_i,
  input  logic            mode_load_i,
  input  logic            mode_load_val_i,
  input  logic [N_IN-1:0] valid_i,
  input  logic [DW-1:0]   dwell_i,
  output logic [N_IN-1:0] sel_o,
  output logic            manual_o,
  output logic            mode_chg_o
);
  localparam logic [N_IN-1:0] SEL_RST = N_IN'(1);

  iss_mode_e       mode;
  logic [N_IN-1:0] sel_q, sel_d, step, hunt;
  logic            found, own_ok, scan_run, tick, sel_en;

  iss_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .tgl_i      (mode_tgl_i),
    .load_i     (mode_load_i),
    .load_val_i (mode_load_val_i),
    .mode_o     (mode),
    .chg_o      (mode_chg_o)
  );

  iss_next_pick #(.N_IN(N_IN)) u_pick (
    .sel_i   (sel_q),
    .valid_i (valid_i),
    .step_o  (step),
    .hunt_o  (hunt),
    .found_o (found)
  );

  assign own_ok   = |(sel_q & valid_i);
  assign scan_run = (mode == SRCH_MODE) && !own_ok;

  iss_dwell_tmr #(.DW(DW)) u_dwell (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (scan_run),
    .clr_i   (btn_press_i),
    .dwell_i (dwell_i),
    .tick_o  (tick)
  );

  assign sel_en = btn_press_i || tick;

  always_comb begin
    sel_d = sel_q;
    if (btn_press_i) begin
      if (mode == MAN_MODE) sel_d = step;
      else if (found)       sel_d = hunt;
    end else if (tick) begin
      sel_d = step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= SEL_RST;
    else if (sel_en) sel_q <= sel_d;
  end

  assign sel_o    = sel_q;
  assign manual_o = (mode == MAN_MODE);
endmodule

// File: rtl/iss_chk.sv
module iss_chk #(
  parameter int N_IN = 3,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            btn_press_i,
  input logic            mode_tgl_i,
  input logic            mode_load_i,
  input logic            mode_load_val_i,
  input logic [N_IN-1:0] valid_i,
  input logic [DW-1:0]   dwell_i,
  input logic [N_IN-1:0] sel_o,
  input logic            manual_o,
  input logic            mode_chg_o
);
  function automatic logic [N_IN-1:0] rotl1(input logic [N_IN-1:0] s);
    return {s[N_IN-2:0], s[N_IN-1]};
  endfunction

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_o) == 1);

  p_man_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    manual_o && btn_press_i |=> sel_o == rotl1($past(sel_o)));

  p_hunt_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_o && btn_press_i && (|(valid_i & ~sel_o)) |=> |(sel_o & $past(valid_i)));

  p_hunt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_o && btn_press_i && !(|(valid_i & ~sel_o)) |=> $stable(sel_o));

  p_toggle_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_tgl_i && !mode_load_i |=> mode_chg_o && (manual_o != $past(manual_o)));

  p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load_i |=> !mode_chg_o && (manual_o == $past(mode_load_val_i)));

  p_fast_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_o && !btn_press_i && !(|(sel_o & valid_i)) && (dwell_i <= DW'(1))
    |=> sel_o == rotl1($past(sel_o)));

  p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !btn_press_i && (manual_o || (|(sel_o & valid_i))) |=> $stable(sel_o));
endmodule

bind input_scan_sel iss_chk #(.N_IN(N_IN), .DW(DW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .btn_press_i     (btn_press_i),
  .mode_tgl_i      (mode_tgl_i),
  .mode_load_i     (mode_load_i),
  .mode_load_val_i (mode_load_val_i),
  .valid_i         (valid_i),
  .dwell_i         (dwell_i),
  .sel_o           (sel_o),
  .manual_o        (manual_o),
  .mode_chg_o      (mode_chg_o)
);

// File: tb/sim_input_scan_sel.sv
`timescale 1ns/1ps
module sim_input_scan_sel;
  localparam int N  = 3;
  localparam int DW = 16;

  logic          clk, rst_n;
  logic          press, tgl, load, lval;
  logic [N-1:0]  valid;
  logic [DW-1:0] dwell;
  logic [N-1:0]  sel;
  logic          man, chg;

  input_scan_sel #(.N_IN(N), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_press_i(press), .mode_tgl_i(tgl),
    .mode_load_i(load), .mode_load_val_i(lval), .valid_i(valid),
    .dwell_i(dwell), .sel_o(sel), .manual_o(man), .mode_chg_o(chg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [N-1:0] sel;
    logic         man;
    logic         chg;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  int   m_sel, m_cnt;
  bit   m_man;

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected state after that edge.
  task automatic cyc(input bit pr, input bit tg, input bit ld, input bit lv,
                     input logic [N-1:0] v, input int d, input string tag);
    bit scan, tick;
    int lim, nsel;
    exp_t e;
    @(negedge clk);
    press = pr; tgl = tg; load = ld; lval = lv; valid = v; dwell = DW'(d);
    scan = !m_man && !v[m_sel];
    lim  = (d == 0) ? 0 : d - 1;
    tick = scan && !pr && (m_cnt >= lim);
    nsel = m_sel;
    if (pr) begin
      if (m_man) nsel = (m_sel + 1) % N;
      else
        for (int k = N - 1; k >= 1; k--)
          if (v[(m_sel + k) % N]) nsel = (m_sel + k) % N;
    end else if (tick) begin
      nsel = (m_sel + 1) % N;
    end
    m_cnt = (!scan || pr || tick) ? 0 : m_cnt + 1;
    m_sel = nsel;
    e.chg = tg && !ld;
    m_man = ld ? lv : (tg ? !m_man : m_man);
    e.sel = N'(1) << m_sel;
    e.man = m_man;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares after each edge, away from the edge itself.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.tag, "sel_o", int'(sel), int'(e.sel));
      check(e.tag, "manual_o", int'(man), int'(e.man));
      check(e.tag, "mode_chg_o", int'(chg), int'(e.chg));
      check("R2", "onehot count", $countones(sel), 1);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; press = 0; tgl = 0; load = 0; lval = 0; valid = '0; dwell = DW'(1000);
    m_sel = 0; m_cnt = 0; m_man = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sel_o", int'(sel), 1);
    check("R1", "manual_o", int'(man), 0);
    check("R1", "mode_chg_o", int'(chg), 0);

    // load manual mode, then step unconditionally with wrap
    cyc(0, 0, 1, 1, 3'b000, 1000, "R7");
    cyc(1, 0, 0, 0, 3'b010, 1000, "R3");
    cyc(1, 0, 0, 0, 3'b010, 1000, "R3");
    cyc(1, 0, 0, 0, 3'b010, 1000, "R3");
    repeat (3) cyc(0, 0, 0, 0, 3'b000, 1, "R9");

    // back to search mode
    cyc(0, 1, 0, 0, 3'b111, 1000, "R6");
    cyc(0, 0, 0, 0, 3'b111, 1000, "R6");

    // search presses
    cyc(1, 0, 0, 0, 3'b101, 1000, "R4");
    cyc(1, 0, 0, 0, 3'b101, 1000, "R4");
    cyc(1, 0, 0, 0, 3'b011, 1000, "R4");
    cyc(1, 0, 0, 0, 3'b010, 1000, "R5");
    repeat (4) cyc(0, 0, 0, 0, 3'b010, 1, "R11");

    // scanning with no input valid
    repeat (10) cyc(0, 0, 0, 0, 3'b000, 3, "R8");
    repeat (8)  cyc(0, 0, 0, 0, 3'b100, 3, "R9");

    // press during a scan dwell
    repeat (2) cyc(0, 0, 0, 0, 3'b000, 4, "R10");
    cyc(1, 0, 0, 0, 3'b000, 4, "R10");
    repeat (6) cyc(0, 0, 0, 0, 3'b000, 4, "R10");

    // zero dwell steps every cycle
    repeat (4) cyc(0, 0, 0, 0, 3'b000, 0, "R8");

    // load beats toggle, then manual never scans
    cyc(0, 1, 1, 1, 3'b000, 1, "R7");
    repeat (3) cyc(0, 0, 0, 0, 3'b000, 1, "R9");
    cyc(0, 1, 0, 0, 3'b001, 1, "R6");
    repeat (3) cyc(0, 0, 0, 0, 3'b001, 1, "R11");

    @(negedge clk);
    press = 0; tgl = 0; load = 0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule